// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

The block is a register-mapped general-purpose I/O controller for up to about a hundred pins. Every register type is split into 32-bit banks. A small synchronous register bus writes and reads those banks. The block drives pin outputs and per-pin output-enables, synchronises the input pins, and turns selected input changes into pending bits. The pending bits are combined into one registered interrupt line.

Each bank holds the following registers:
- pin enable
- output value
- direction
- synchronised input value (read only)
- interrupt mask
- pending status
- edge polarity

The enable register and the edge-polarity register can each be left out at build time. Without the polarity register, the interrupt is level-sensitive and active-high. A build option swaps the identity pin-to-bit layout for a fixed remapped layout. In the remapped layout some pins have no register bit at all.

Software uses the block in this order:
1. Set a pin's direction, enable and mask.
2. Wait for `irq_o`.
3. Read the pending word.
4. Acknowledge by writing zeros to the bits it has handled.

Top module: `gpio_banked`

## Requirements
- R1: A register word is addressed as `addr_i = {code[2:0], bank}`, where `bank` is the low `BANK_W` bits. The codes are: 0 enable, 1 output value, 2 direction, 3 input value, 4 mask, 5 pending, 6 edge polarity. Read data appears on `rdata_o` on the clock edge that accepts the read. Without remap, pin n sits in bank n/32 at bit n%32.
- R2: After reset every direction bit of an existing pin is 1 (input). All other registers, the pending bits, `gpio_oe_o` and `irq_o` are 0.
- R3: `gpio_oe_o` of a pin is its enable bit AND NOT its direction bit. `gpio_o` follows the output-value bit. Both change on the edge that writes the register.
- R4: The input-value register returns each pin through a two-flop synchroniser. A read accepted on the first edge after a pin change still returns the old value. A read accepted on the third edge returns the new value.
- R5: A mask bit of 1 stops that pin from setting its pending bit.
- R6: Writing 0 to a pending bit clears it, and writing 1 leaves it unchanged. When a new event and a clearing write fall on the same edge, the bit stays set.
- R7: With an edge polarity bit of 1, a rising synchronised input sets the pending bit. With a polarity bit of 0, a falling input sets it. The opposite edge is ignored.
- R8: `irq_o` is the OR of all pending bits, registered one cycle behind them. A pin change therefore raises `irq_o` on the fourth edge after the change.
- R9: Register bits with no pin behind them read 0, never become pending, and ignore writes. In the default build these are bank 3, bits 6 to 31.
- R10: A pending bit is set only while the pin is enabled and is an input (direction 1).
- R11: With `REMAP` set, the pin-to-bit layout is:
  - pins 0 to 27 use bit pin+4;
  - pins 34 to 97 use bit pin-2;
  - pins 98 to 101 use bit 101-pin;
  - pins 28 to 33 have no bit. They never drive, are never enabled as outputs, and never reach the input or pending registers.
- R12: Without the edge polarity register, a pending bit is set on every cycle in which the synchronised input is high and the pin is armed.
- R13: Without the enable register, every existing pin counts as enabled. An absent register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | {register code, bank} |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| gpio_i | input | NUM_PINS | Pin inputs |
| gpio_o | output | NUM_PINS | Pin output values |
| gpio_oe_o | output | NUM_PINS | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Register writes take effect on the edge that accepts them, so pin outputs are sampled at the falling edge right after the write. Pin inputs reach the input register two edges after they change. The bench reads once too early on purpose, expecting the old value, and then reads again. A pending bit sets on the third edge after an input change and `irq_o` follows on the fourth. The bench counts these edges explicitly and checks `irq_o` both one cycle before and at the due edge. To test clear-versus-set, the bench issues the clearing write while the level source is still high.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    CSR_ENABLE = 3'd0,
    CSR_OUT    = 3'd1,
    CSR_DIR    = 3'd2,
    CSR_IN     = 3'd3,
    CSR_MASK   = 3'd4,
    CSR_PEND   = 3'd5,
    CSR_EDGE   = 3'd6
  } csr_code_e;

  // register bit for a pin, -1 when the pin has no bit
  function automatic int pin_slot(bit remap, int pin, int nbit);
    int b;
    if (!remap)          b = pin;
    else if (pin <= 27)  b = pin + 4;
    else if (pin <= 33)  b = -1;
    else if (pin <= 97)  b = pin - 2;
    else if (pin <= 101) b = 101 - pin;
    else                 b = -1;
    if (b >= nbit) b = -1;
    return b;
  endfunction

  function automatic int slot_pin(bit remap, int npins, int nbit, int slot);
    int p;
    p = -1;
    for (int i = 0; i < npins; i++)
      if (pin_slot(remap, i, nbit) == slot) p = i;
    return p;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_pin_map.sv
`timescale 1ns/1ps
module gpio_pin_map
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 102,
  parameter int NBIT     = 128,
  parameter bit REMAP    = 1'b0
) (
  input  logic [NBIT-1:0]     out_bits_i,
  input  logic [NBIT-1:0]     oe_bits_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NBIT-1:0]     in_bits_o,
  output logic [NBIT-1:0]     valid_o
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int S = pin_slot(REMAP, n, NBIT);
    if (S >= 0) begin : g_map
      assign pin_o[n]    = out_bits_i[S];
      assign pin_oe_o[n] = oe_bits_i[S];
    end else begin : g_none
      assign pin_o[n]    = 1'b0;
      assign pin_oe_o[n] = 1'b0;
    end
  end

  for (genvar b = 0; b < NBIT; b++) begin : g_slot
    localparam int P = slot_pin(REMAP, NUM_PINS, NBIT, b);
    if (P >= 0) begin : g_map
      assign in_bits_o[b] = pin_i[P];
      assign valid_o[b]   = 1'b1;
    end else begin : g_none
      assign in_bits_o[b] = 1'b0;
      assign valid_o[b]   = 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^((out_bits_i | oe_bits_i) & ~valid_o);
endmodule

// File: rtl/gpio_csr.sv
`timescale 1ns/1ps
module gpio_csr
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_W     = 2,
  parameter bit HAS_ENABLE = 1'b1,
  parameter bit HAS_EDGE   = 1'b1,
  localparam int NBIT      = NUM_BANKS * WORD_W,
  localparam int ADDR_W    = 3 + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [NBIT-1:0]   valid_i,
  input  logic [NBIT-1:0]   in_bits_i,
  input  logic [NBIT-1:0]   pend_i,
  output logic [NBIT-1:0]   en_o,
  output logic [NBIT-1:0]   out_o,
  output logic [NBIT-1:0]   dir_o,
  output logic [NBIT-1:0]   mask_o,
  output logic [NBIT-1:0]   edge_o,
  output logic [NBIT-1:0]   clr_o
);
  csr_code_e         sel;
  logic [BANK_W-1:0] bank;
  logic              bank_ok, wr;
  logic [WORD_W-1:0] rd_word [NUM_BANKS];

  assign sel     = csr_code_e'(addr_i[ADDR_W-1 -: 3]);
  assign bank    = addr_i[BANK_W-1:0];
  assign bank_ok = (int'(bank) < NUM_BANKS);
  assign wr      = req_i && we_i && bank_ok;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic [WORD_W-1:0] v, out_q, dir_q, mask_q, en_rd, edge_rd, merged;
    logic              hit;

    assign v      = valid_i[k*WORD_W +: WORD_W];
    assign hit    = wr && (bank == BANK_W'(k));
    // bits without a pin keep their value
    assign merged = wdata_i & v;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q  <= '0;
        dir_q  <= v;
        mask_q <= '0;
      end else if (hit) begin
        if (sel == CSR_OUT)  out_q  <= merged | (out_q & ~v);
        if (sel == CSR_DIR)  dir_q  <= merged | (dir_q & ~v);
        if (sel == CSR_MASK) mask_q <= merged | (mask_q & ~v);
      end
    end

    if (HAS_ENABLE) begin : g_en
      logic [WORD_W-1:0] en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       en_q <= '0;
        else if (hit && sel == CSR_ENABLE) en_q <= merged | (en_q & ~v);
      end
      assign en_rd = en_q;
      assign en_o[k*WORD_W +: WORD_W] = en_q;
    end else begin : g_no_en
      assign en_rd = '0;
      assign en_o[k*WORD_W +: WORD_W] = v;
    end

    if (HAS_EDGE) begin : g_edge
      logic [WORD_W-1:0] edge_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     edge_q <= '0;
        else if (hit && sel == CSR_EDGE) edge_q <= merged | (edge_q & ~v);
      end
      assign edge_rd = edge_q;
    end else begin : g_no_edge
      assign edge_rd = '0;
    end

    assign out_o [k*WORD_W +: WORD_W] = out_q;
    assign dir_o [k*WORD_W +: WORD_W] = dir_q;
    assign mask_o[k*WORD_W +: WORD_W] = mask_q;
    assign edge_o[k*WORD_W +: WORD_W] = edge_rd;
    assign clr_o [k*WORD_W +: WORD_W] = (hit && sel == CSR_PEND) ? (~wdata_i & v) : '0;

    always_comb begin
      case (sel)
        CSR_ENABLE: rd_word[k] = en_rd;
        CSR_OUT:    rd_word[k] = out_q;
        CSR_DIR:    rd_word[k] = dir_q;
        CSR_IN:     rd_word[k] = in_bits_i[k*WORD_W +: WORD_W];
        CSR_MASK:   rd_word[k] = mask_q;
        CSR_PEND:   rd_word[k] = pend_i[k*WORD_W +: WORD_W];
        CSR_EDGE:   rd_word[k] = edge_rd;
        default:    rd_word[k] = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   rdata_o <= '0;
    else if (req_i && !we_i)       rdata_o <= bank_ok ? rd_word[bank] : '0;
  end

  // R9: storage behind missing pins stays cleared
  p_unmapped_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_o | dir_o | mask_o | edge_o) & ~valid_i) == '0);
endmodule

// File: rtl/gpio_irq.sv
`timescale 1ns/1ps
module gpio_irq #(
  parameter int NBIT     = 128,
  parameter bit HAS_EDGE = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NBIT-1:0] cur_i,
  input  logic [NBIT-1:0] valid_i,
  input  logic [NBIT-1:0] en_i,
  input  logic [NBIT-1:0] dir_i,
  input  logic [NBIT-1:0] mask_i,
  input  logic [NBIT-1:0] edge_i,
  input  logic [NBIT-1:0] clr_i,
  output logic [NBIT-1:0] pend_o
);
  logic [NBIT-1:0] hit, arm, pend_q;

  assign arm = en_i & dir_i & ~mask_i & valid_i;

  if (HAS_EDGE) begin : g_edge
    logic [NBIT-1:0] prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= cur_i;
    end
    assign hit = (edge_i & cur_i & ~prev_q) | (~edge_i & ~cur_i & prev_q);
  end else begin : g_level
    logic unused_edge;
    assign unused_edge = ^edge_i;
    assign hit = cur_i;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | (hit & arm);
  end

  assign pend_o = pend_q;

  // R6: a pending bit only drops after a clearing write
  p_clear_by_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0);
  // R10: a pending bit only rises on an armed pin
  p_set_needs_arm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~$past(pend_q) & pend_q & ~$past(arm)) == '0);
  // R9: bits without a pin never pend
  p_pend_mapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~valid_i) == '0);
endmodule

// File: rtl/gpio_banked.sv
`timescale 1ns/1ps
module gpio_banked
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS   = 102,
  parameter bit REMAP      = 1'b0,
  parameter bit HAS_ENABLE = 1'b1,
  parameter bit HAS_EDGE   = 1'b1,
  localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = 3 + BANK_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] gpio_i,
  output logic [NUM_PINS-1:0] gpio_o,
  output logic [NUM_PINS-1:0] gpio_oe_o,
  output logic                irq_o
);
  localparam int NBIT = NUM_BANKS * WORD_W;

  logic [NUM_PINS-1:0] pin_sync;
  logic [NBIT-1:0] in_bits, valid, en, out, dir, mask, edge_sel, clr, pend, oe_bits;
  logic            irq_q;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(gpio_i), .q_o(pin_sync)
  );

  assign oe_bits = en & ~dir;

  gpio_pin_map #(.NUM_PINS(NUM_PINS), .NBIT(NBIT), .REMAP(REMAP)) u_map (
    .out_bits_i(out), .oe_bits_i(oe_bits), .pin_i(pin_sync),
    .pin_o(gpio_o), .pin_oe_o(gpio_oe_o), .in_bits_o(in_bits), .valid_o(valid)
  );

  gpio_csr #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
             .HAS_ENABLE(HAS_ENABLE), .HAS_EDGE(HAS_EDGE)) u_csr (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .valid_i(valid), .in_bits_i(in_bits), .pend_i(pend),
    .en_o(en), .out_o(out), .dir_o(dir), .mask_o(mask), .edge_o(edge_sel), .clr_o(clr)
  );

  gpio_irq #(.NBIT(NBIT), .HAS_EDGE(HAS_EDGE)) u_irq (
    .clk_i, .rst_ni, .cur_i(in_bits), .valid_i(valid), .en_i(en), .dir_i(dir),
    .mask_i(mask), .edge_i(edge_sel), .clr_i(clr), .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend;
  end

  assign irq_o = irq_q;

  // R8: interrupt tracks pending bits one cycle later
  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend) |=> irq_o);
  p_irq_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|pend) |=> !irq_o);
endmodule

// File: tb/sim_gpio_banked.sv
`timescale 1ns/1ps
module sim_gpio_banked;
  localparam logic [2:0] C_EN = 3'd0, C_OUT = 3'd1, C_DIR = 3'd2, C_IN = 3'd3,
                         C_MASK = 3'd4, C_PEND = 3'd5, C_EDGE = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         req0 = 0, we0 = 0, req1 = 0, we1 = 0;
  logic [4:0]   addr0 = '0, addr1 = '0;
  logic [31:0]  wdata0 = '0, wdata1 = '0, rdata0, rdata1;
  logic [101:0] gi0 = '0, gi1 = '0, go0, go1, goe0, goe1;
  logic         irq0, irq1;

  int n_chk = 0, n_bad = 0, cyc = 0;

  gpio_banked u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req0), .we_i(we0), .addr_i(addr0),
    .wdata_i(wdata0), .rdata_o(rdata0), .gpio_i(gi0), .gpio_o(go0),
    .gpio_oe_o(goe0), .irq_o(irq0)
  );

  gpio_banked #(.REMAP(1'b1), .HAS_ENABLE(1'b0), .HAS_EDGE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .we_i(we1), .addr_i(addr1),
    .wdata_i(wdata1), .rdata_o(rdata1), .gpio_i(gi1), .gpio_o(go1),
    .gpio_oe_o(goe1), .irq_o(irq1)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int d, input logic [2:0] code, input int bank, input logic [31:0] data);
    @(negedge clk);
    if (d == 0) begin req0 = 1; we0 = 1; addr0 = {code, 2'(bank)}; wdata0 = data; end
    else        begin req1 = 1; we1 = 1; addr1 = {code, 2'(bank)}; wdata1 = data; end
    @(negedge clk);
    req0 = 0; we0 = 0; req1 = 0; we1 = 0;
  endtask

  task automatic rd(input int d, input logic [2:0] code, input int bank, output logic [31:0] data);
    @(negedge clk);
    if (d == 0) begin req0 = 1; we0 = 0; addr0 = {code, 2'(bank)}; end
    else        begin req1 = 1; we1 = 0; addr1 = {code, 2'(bank)}; end
    @(negedge clk);
    req0 = 0; req1 = 0;
    data = (d == 0) ? rdata0 : rdata1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd(0, C_DIR, 0, r);  check("R2 dir bank0", r, 32'hffff_ffff);
    rd(0, C_DIR, 3, r);  check("R9 dir bank3", r, 32'h0000_003f);
    rd(0, C_EN, 0, r);   check("R2 enable", r, 0);
    rd(0, C_PEND, 0, r); check("R2 pending", r, 0);
    check("R2 oe", goe0[31:0], 0);
    check("R2 irq", {31'b0, irq0}, 0);
  endtask

  task automatic t_drive();
    wr(0, C_EN, 0, 32'h0000_00ff);
    wr(0, C_DIR, 0, 32'hffff_ff0f);
    wr(0, C_OUT, 0, 32'h0000_0050);
    check("R3 oe bank0", goe0[31:0], 32'h0000_00f0);
    check("R3 out bank0", go0[31:0], 32'h0000_0050);
    wr(0, C_EN, 1, 32'h0000_0100);
    wr(0, C_DIR, 1, 32'hffff_feff);
    wr(0, C_OUT, 1, 32'h0000_0100);
    check("R1 pin40 oe", goe0[63:32], 32'h0000_0100);
    check("R1 pin40 out", go0[63:32], 32'h0000_0100);
  endtask

  task automatic t_input();
    logic [31:0] r;
    gi0[64] = 1'b1;
    rd(0, C_IN, 2, r);   check("R4 early read", r, 0);
    rd(0, C_IN, 2, r);   check("R4 pin64", r, 32'h1);
    gi0[33] = 1'b1; gi0[100] = 1'b1;
    edges(2);
    rd(0, C_IN, 1, r);   check("R4 pin33", r, 32'h2);
    rd(0, C_IN, 3, r);   check("R1 pin100", r, 32'h10);
  endtask

  task automatic t_edges();
    logic [31:0] r;
    wr(0, C_EDGE, 0, 32'h4);
    gi0[2] = 1'b1;
    edges(3);            check("R8 irq lag", {31'b0, irq0}, 0);
    edges(1);            check("R8 irq due", {31'b0, irq0}, 1);
    rd(0, C_PEND, 0, r); check("R7 rising", r, 32'h4);
    wr(0, C_PEND, 0, 32'hffff_ffff);
    rd(0, C_PEND, 0, r); check("R6 write one keeps", r, 32'h4);
    gi0[2] = 1'b0;
    edges(4);
    rd(0, C_PEND, 0, r); check("R7 fall ignored", r, 32'h4);
    wr(0, C_PEND, 0, 32'hffff_fffb);
    rd(0, C_PEND, 0, r); check("R6 write zero clears", r, 0);
    check("R8 irq drop", {31'b0, irq0}, 0);
    wr(0, C_EDGE, 0, 32'h0);
    gi0[2] = 1'b1;
    edges(4);
    rd(0, C_PEND, 0, r); check("R7 rise ignored", r, 0);
    gi0[2] = 1'b0;
    edges(4);
    rd(0, C_PEND, 0, r); check("R7 falling", r, 32'h4);
    wr(0, C_PEND, 0, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] r;
    wr(0, C_MASK, 0, 32'h4);
    gi0[2] = 1'b1; edges(4);
    gi0[2] = 1'b0; edges(4);
    rd(0, C_PEND, 0, r); check("R5 masked", r, 0);
    check("R5 irq", {31'b0, irq0}, 0);
    wr(0, C_MASK, 0, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] r;
    wr(0, C_EDGE, 0, 32'h20);
    gi0[5] = 1'b1; gi0[10] = 1'b1; edges(4);
    gi0[5] = 1'b0; gi0[10] = 1'b0; edges(4);
    rd(0, C_PEND, 0, r); check("R10 output or disabled", r, 0);
    wr(0, C_EN, 0, 32'h0000_04ff);
    gi0[10] = 1'b1; edges(4);
    gi0[10] = 1'b0; edges(4);
    rd(0, C_PEND, 0, r); check("R10 enabled input", r, 32'h400);
    wr(0, C_PEND, 0, 32'h0);
  endtask

  task automatic t_last();
    logic [31:0] r;
    wr(0, C_EN, 3, 32'hffff_ffff);
    rd(0, C_EN, 3, r);   check("R9 enable bank3", r, 32'h3f);
    wr(0, C_OUT, 3, 32'hffff_ffc0);
    rd(0, C_OUT, 3, r);  check("R9 out bank3", r, 0);
  endtask

  task automatic t_remap();
    logic [31:0] r;
    rd(1, C_DIR, 3, r);  check("R11 dir bank3", r, 0);
    rd(1, C_DIR, 2, r);  check("R11 dir bank2", r, 32'hffff_ffff);
    rd(1, C_EN, 0, r);   check("R13 absent enable", r, 0);
    wr(1, C_DIR, 0, 32'hffff_ffee);
    wr(1, C_OUT, 0, 32'h11);
    check("R13 oe pins101,4,0", {29'b0, goe1[101], goe1[4], goe1[0]}, 32'h5);
    check("R11 out pins101,0", {30'b0, go1[101], go1[0]}, 32'h3);
    gi1[34] = 1'b1; edges(2);
    rd(1, C_IN, 1, r);   check("R11 pin34 bit32", r, 32'h1);
    rd(1, C_PEND, 1, r); check("R12 level pending", r, 32'h1);
    check("R12 irq", {31'b0, irq1}, 1);
    wr(1, C_PEND, 1, 32'h0);
    rd(1, C_PEND, 1, r); check("R6 set wins", r, 32'h1);
    gi1[34] = 1'b0; edges(3);
    wr(1, C_PEND, 1, 32'h0);
    rd(1, C_PEND, 1, r); check("R12 cleared", r, 0);
    check("R12 irq low", {31'b0, irq1}, 0);
    gi1[30] = 1'b1; edges(4);
    rd(1, C_IN, 0, r);   check("R11 pin30 no bit", r, 0);
    rd(1, C_PEND, 0, r); check("R11 pin30 pending", r, 0);
    check("R11 pin30 pads", {30'b0, go1[30], goe1[30]}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_drive();
    t_input();
    t_edges();
    t_mask();
    t_gate();
    t_last();
    t_remap();
    finish_run();
  end
endmodule